// File: doc/BRIEF.md
# Overwriting Receive Byte Ring

This block holds decoded bytes from a serial bit decoder until the host collects them. Each byte that arrives without an error flag goes into a small ring of byte slots. A host read strobe takes the bytes back out in arrival order. A fill counter shows the host how many bytes are waiting.

The ring never refuses a byte. When it is full, each new byte replaces the oldest one still stored, so the ring always keeps the most recent bytes. An interrupt pulse tells the host that the fill level has climbed to a threshold, which a 2-bit selector picks. The threshold is only tested while the level is rising. A configuration-write strobe empties the ring at once. The serial host link is not part of this block: a read strobe and a registered data output stand in for it.

Top module: `rx_byte_ring`

## Requirements
- R1: After reset, fillCount is 0, rdData is 0x00 and irqOut is 0.
- R2: A pulse on rdStrobe while fillCount is not zero puts the oldest stored byte on rdData one clock later. rdData then holds that byte until the next read or empty read. Bytes come out in the order they were stored.
- R3: A stored byte raises fillCount by one, and a read of a non-empty ring lowers it by one. The new value shows one clock after the event.
- R4: A byte offered with inValid=1 and inErr=1 is discarded. It does not change fillCount, and it never appears on rdData.
- R5: With DEPTH=16, fillCount never exceeds 16. When a store arrives at a full ring with no read, fillCount stays 16 and the oldest byte is dropped. Later reads return the 16 newest bytes, oldest first.
- R6: irqOut is a one-clock pulse that shows one clock after a store that raises fillCount to the threshold. thrSel encodes the threshold as 00 = 1 byte, 01 = 4, 10 = 8 and 11 = 12.
- R7: A store and a read of a non-empty ring in the same clock leave fillCount unchanged and raise no interrupt. A fill level that falls to the threshold raises no interrupt either.
- R8: A read strobe while fillCount is 0 puts 0x00 on rdData one clock later and leaves fillCount at 0.
- R9: A pulse on cfgWrite empties the ring one clock later: fillCount is 0 and irqOut is 0. cfgWrite wins over a store or read in the same clock, and afterwards the ring reads as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A decoded byte is offered this clock |
| inData | input | 8 | Decoded byte |
| inErr | input | 1 | The offered byte contained a bit error |
| rdStrobe | input | 1 | Host read request, one clock per byte |
| thrSel | input | 2 | Interrupt threshold selector |
| cfgWrite | input | 1 | Configuration write; empties the ring |
| rdData | output | 8 | Byte returned by the last read |
| fillCount | output | 5 | Number of bytes waiting, 0 to 16 |
| irqOut | output | 1 | Threshold-reached pulse |

## Verification
A vector table mixes stores, discarded error bytes and reads. It separates a design that keeps arrival order and drops flagged bytes from one that reorders them or stores them. Each of the four threshold codes is driven by filling from empty. This shows whether the pulse fires exactly once, at the encoded level. A run of 20 stores into the 16-slot ring, followed by a full drain, tells true overwriting of the oldest bytes from blocking, or from reading stale slots. The directed cases come last:
- a store and a read in the same clock;
- a fill level that falls back to the threshold;
- a read of an empty ring;
- a clear that coincides with a store.

They show whether the design avoids spurious interrupts and lets the clear take priority.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);

  typedef struct packed {
    logic          wrEn;
    logic          rdEn;
    logic          rdEmpty;
    logic [AW-1:0] wrIdx;
    logic [AW-1:0] rdIdx;
  } ringStrobes_t;
endpackage

// File: rtl/rbr_ctrl.sv
module rbr_ctrl
  import rbr_pkg::*;
#(
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inErr,
  input  logic          rdStrobe,
  input  logic [1:0]    thrSel,
  input  logic          cfgWrite,
  output ringStrobes_t  strobes,
  output logic [CW-1:0] fillCount,
  output logic          irqOut
);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count, countUp, thrLevel;
  logic          store, effRd, full, rdAdv;

  always_comb begin
    case (thrSel)
      2'd0:    thrLevel = CW'(1);
      2'd1:    thrLevel = CW'(DEPTH / 4);
      2'd2:    thrLevel = CW'(DEPTH / 2);
      default: thrLevel = CW'((3 * DEPTH) / 4);
    endcase
  end

  assign store   = inValid && !inErr;
  assign full    = (count == CNT_MAX);
  assign effRd   = rdStrobe && (count != '0);
  assign rdAdv   = effRd || (store && full);
  assign countUp = count + CNT_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      irqOut <= 1'b0;
    end else if (cfgWrite) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      irqOut <= 1'b0;
    end else begin
      if (store) wrPtr <= wrPtr + PTR_ONE;
      if (rdAdv) rdPtr <= rdPtr + PTR_ONE;
      if (store && !effRd && !full) count <= countUp;
      else if (effRd && !store)     count <= count - CNT_ONE;
      irqOut <= store && !effRd && !full && (countUp == thrLevel);
    end
  end

  always_comb begin
    strobes.wrEn    = store && !cfgWrite;
    strobes.rdEn    = effRd && !cfgWrite;
    strobes.rdEmpty = rdStrobe && (count == '0) && !cfgWrite;
    strobes.wrIdx   = wrPtr;
    strobes.rdIdx   = rdPtr;
  end

  assign fillCount = count;
endmodule

// File: rtl/rbr_data.sv
module rbr_data
  import rbr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ringStrobes_t  strobes,
  input  logic [DW-1:0] inData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) slots[strobes.wrIdx] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobes.rdEn)    rdData <= slots[strobes.rdIdx];
    else if (strobes.rdEmpty) rdData <= '0;
  end
endmodule

// File: rtl/rx_byte_ring.sv
module rx_byte_ring
  import rbr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  input  logic          inErr,
  input  logic          rdStrobe,
  input  logic [1:0]    thrSel,
  input  logic          cfgWrite,
  output logic [DW-1:0] rdData,
  output logic [AW:0]   fillCount,
  output logic          irqOut
);
  ringStrobes_t strobes;

  rbr_ctrl #(.CW(AW + 1)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inErr(inErr),
    .rdStrobe(rdStrobe), .thrSel(thrSel), .cfgWrite(cfgWrite),
    .strobes(strobes), .fillCount(fillCount), .irqOut(irqOut)
  );

  rbr_data uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inData(inData), .rdData(rdData)
  );
endmodule

// File: rtl/rbr_checker.sv
module rbr_checker
  import rbr_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inErr,
  input logic          rdStrobe,
  input logic          cfgWrite,
  input logic [DW-1:0] rdData,
  input logic [AW:0]   fillCount,
  input logic          irqOut
);
  AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= (AW+1)'(DEPTH)); // R5

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (fillCount - $past(fillCount)) == (AW+1)'(1)); // R6

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (fillCount == '0) && !irqOut); // R9

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fillCount == '0 && !cfgWrite) |=> rdData == '0); // R8

  AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inErr && !rdStrobe && !cfgWrite) |=> $stable(fillCount)); // R4

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inErr && rdStrobe && fillCount != '0 && !cfgWrite)
      |=> $stable(fillCount) && !irqOut); // R7
endmodule

bind rx_byte_ring rbr_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inErr(inErr),
  .rdStrobe(rdStrobe), .cfgWrite(cfgWrite), .rdData(rdData),
  .fillCount(fillCount), .irqOut(irqOut)
);

// File: tb/tb_rx_byte_ring.sv
module tb_rx_byte_ring;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inErr = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [1:0] thrSel = 2'd3;
  logic       cfgWrite = 1'b0;
  logic [7:0] rdData;
  logic [4:0] fillCount;
  logic       irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_byte_ring dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inErr(inErr), .rdStrobe(rdStrobe), .thrSel(thrSel),
    .cfgWrite(cfgWrite), .rdData(rdData), .fillCount(fillCount),
    .irqOut(irqOut)
  );

  // Vector: [15:14] op (0 push, 1 pop), [13] err, [12:8] count after, [7:0] data
  localparam int NV = 9;
  localparam logic [15:0] VECS [NV] = '{
    {2'd0, 1'b0, 5'd1, 8'hA5},
    {2'd0, 1'b0, 5'd2, 8'h3C},
    {2'd0, 1'b1, 5'd2, 8'hFF},
    {2'd0, 1'b0, 5'd3, 8'h81},
    {2'd1, 1'b0, 5'd2, 8'hA5},
    {2'd0, 1'b0, 5'd3, 8'h7E},
    {2'd1, 1'b0, 5'd2, 8'h3C},
    {2'd1, 1'b0, 5'd1, 8'h81},
    {2'd1, 1'b0, 5'd0, 8'h7E}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive for one clock; sample 1 ns after the edge.
  task automatic cycle(input bit v, input logic [7:0] d, input bit e, input bit r, input bit c);
    @(negedge clk);
    inValid = v; inData = d; inErr = e; rdStrobe = r; cfgWrite = c;
    @(posedge clk);
    #1;
    @(negedge clk);
    inValid = 1'b0; inErr = 1'b0; rdStrobe = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic sample_after(input bit v, input logic [7:0] d, input bit e, input bit r, input bit c);
    @(negedge clk);
    inValid = v; inData = d; inErr = e; rdStrobe = r; cfgWrite = c;
    @(posedge clk);
    #1;
    inValid = 1'b0; inErr = 1'b0; rdStrobe = 1'b0; cfgWrite = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int irqCnt, irqAt, expThr;
    repeat (3) @(posedge clk);
    #1;
    check(fillCount == 0 && rdData == 0 && irqOut == 0, "R1 reset state",
          {fillCount, rdData, 7'd0, irqOut}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      sample_after(VECS[i][15:14] == 2'd0, VECS[i][7:0], VECS[i][13],
                   VECS[i][15:14] == 2'd1, 1'b0);
      check(fillCount == VECS[i][12:8], $sformatf("R3 R4 count vec %0d", i),
            fillCount, VECS[i][12:8]);
      if (VECS[i][15:14] == 2'd1)
        check(rdData == VECS[i][7:0], $sformatf("R2 data vec %0d", i),
              rdData, VECS[i][7:0]);
    end

    // R6 thresholds
    for (int s = 0; s < 4; s++) begin
      cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      thrSel = 2'(s);
      expThr = (s == 0) ? 1 : s * 4;
      irqCnt = 0; irqAt = 0;
      for (int k = 1; k <= 13; k++) begin
        sample_after(1'b1, 8'(k), 1'b0, 1'b0, 1'b0);
        if (irqOut) begin irqCnt++; irqAt = k; end
      end
      check(irqCnt == 1 && irqAt == expThr, $sformatf("R6 threshold sel %0d", s),
            irqAt, expThr);
    end

    // R7: store+read together, and falling to threshold
    cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    thrSel = 2'd1;
    for (int k = 0; k < 3; k++) cycle(1'b1, 8'h10, 1'b0, 1'b0, 1'b0);
    sample_after(1'b1, 8'h11, 1'b0, 1'b1, 1'b0);
    check(fillCount == 3 && irqOut == 0, "R7 store and read same clock",
          {fillCount, 3'd0, irqOut}, 8'h30);
    cycle(1'b1, 8'h12, 1'b0, 1'b0, 1'b0);
    cycle(1'b1, 8'h13, 1'b0, 1'b0, 1'b0);
    sample_after(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check(fillCount == 4 && irqOut == 0, "R7 falling to threshold",
          {fillCount, 3'd0, irqOut}, 8'h40);

    // R5 overflow
    cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    thrSel = 2'd3;
    for (int k = 0; k < 20; k++) cycle(1'b1, 8'(8'h40 + k), 1'b0, 1'b0, 1'b0);
    #1;
    check(fillCount == 16, "R5 saturated count", fillCount, 16);
    begin
      bit ok = 1'b1;
      int badAct = 0, badExp = 0;
      for (int k = 0; k < 16; k++) begin
        sample_after(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        if (ok && rdData != 8'(8'h44 + k)) begin
          ok = 1'b0; badAct = rdData; badExp = 8'h44 + k;
        end
      end
      check(ok, "R5 oldest surviving order", badAct, badExp);
    end
    check(fillCount == 0, "R5 drained count", fillCount, 0);

    // R8 empty read (rdData last held 0x53)
    sample_after(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check(rdData == 0 && fillCount == 0, "R8 empty read",
          {fillCount, rdData}, 0);

    // R9 clear with coincident store
    for (int k = 0; k < 3; k++) cycle(1'b1, 8'h66, 1'b0, 1'b0, 1'b0);
    sample_after(1'b1, 8'h77, 1'b0, 1'b0, 1'b1);
    check(fillCount == 0 && irqOut == 0, "R9 clear count", fillCount, 0);
    sample_after(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check(rdData == 0 && fillCount == 0, "R9 reads empty after clear",
          {fillCount, rdData}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule